// File: doc/BRIEF.md
# Two-Level Exception Entry Controller

This block decides when a processor core leaves its current flow for one of two interrupt classes: a normal request and a fast request. Both requests arrive active-low and level-sensitive from outside the clock domain. Each request passes through a synchronizer and is then arbitrated at instruction boundaries, which are marked by `take_ok`. The fast class always wins. The block owns the mode field and the two mask bits. On entry it switches mode, raises the masks that belong to the class taken, and drives the vector address. It also captures a link value and the pre-entry status word in a bank kept for that class.

The two classes mask each other unequally. Taking a fast request blocks every further request until return. Taking a normal request blocks only other normal requests, so a fast request can still preempt a running normal handler. An exception-return command restores the status saved in the bank of the current mode. It also produces the resume address, which is the banked link value minus 4. Software changes the two mask bits through a write strobe.

Top module: `excp_entry_ctl`

## Requirements
- R1: After reset the mode is user (5'b10000), both mask bits are 1, and `take`, `saved_we` and `ret_valid` are 0.
- R2: A request held low with its mask clear and `take_ok` high raises `take` for one cycle on the third rising edge after the request is applied. `vec_addr` is 0x1C for the fast class and 0x18 for the normal class.
- R3: When both requests are pending in the same cycle, the fast request is taken. The normal request is not taken while the fast handler runs.
- R4: Fast entry sets the mode to 5'b10001 and sets both `nmask` and `fmask`.
- R5: Normal entry sets the mode to 5'b10010 and sets `nmask`, leaving `fmask` unchanged. A fast request taken during the normal handler preempts it.
- R6: No request is taken while its mask bit is 1 or while `take_ok` is 0.
- R7: On entry, `link` equals `pc_in`+4 and `saved_we` pulses. `saved_stat` holds the pre-entry status word, laid out as bit 7 `nmask`, bit 6 `fmask`, bit 5 zero and bits 4:0 the mode.
- R8: `eret` in a handler mode restores mode and masks from that mode's bank on the next edge. In the same cycle `ret_valid` pulses and `ret_pc` equals the banked link minus 4.
- R9: `eret` in user mode has no effect. An `eret` in a handler mode takes precedence over an entry and over a mask write in the same cycle.
- R10: With `mask_we` high and no entry or return in that cycle, `fmask` takes `mask_wdata[1]` and `nmask` takes `mask_wdata[0]` on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| nrm_req_n | input | 1 | Normal interrupt request, active low, asynchronous |
| fst_req_n | input | 1 | Fast interrupt request, active low, asynchronous |
| take_ok | input | 1 | Instruction boundary; entry may occur |
| pc_in | input | AW | Return address of the interrupted flow |
| mask_we | input | 1 | Mask write strobe |
| mask_wdata | input | 2 | New masks: [1] fast, [0] normal |
| eret | input | 1 | Exception-return command |
| take | output | 1 | One-cycle entry strobe |
| vec_addr | output | AW | Vector of the last entry |
| mode | output | 5 | Current processor mode |
| nmask | output | 1 | Normal-request mask |
| fmask | output | 1 | Fast-request mask |
| link | output | AW | Link value written on the last entry |
| saved_we | output | 1 | Saved-status strobe |
| saved_stat | output | 8 | Status word saved on the last entry |
| ret_valid | output | 1 | One-cycle return strobe |
| ret_pc | output | AW | Resume address on return |

## Verification
The assertions assume that `eret` is issued only from a state the block itself entered, so the bank read on return holds a value written by an entry or by reset. They also assume that `pc_in` is stable in the cycle before an entry edge. The stimulus changes all inputs only on falling edges. It gives `pc_in` its value well before each request, and it issues `eret` only after a matching entry or, on purpose, in user mode, where the command has no effect.

// File: rtl/excp_entry_ctl.sv
module excp_entry_ctl #(
  parameter int          AW    = 32,
  parameter int          SYNC  = 2,
  parameter logic [AW-1:0] F_VEC = 'h1C,
  parameter logic [AW-1:0] N_VEC = 'h18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          nrm_req_n,
  input  logic          fst_req_n,
  input  logic          take_ok,
  input  logic [AW-1:0] pc_in,
  input  logic          mask_we,
  input  logic [1:0]    mask_wdata,
  input  logic          eret,
  output logic          take,
  output logic [AW-1:0] vec_addr,
  output logic [4:0]    mode,
  output logic          nmask,
  output logic          fmask,
  output logic [AW-1:0] link,
  output logic          saved_we,
  output logic [7:0]    saved_stat,
  output logic          ret_valid,
  output logic [AW-1:0] ret_pc
);
  localparam logic [4:0] M_USR = 5'b10000;
  localparam logic [4:0] M_FST = 5'b10001;
  localparam logic [4:0] M_NRM = 5'b10010;

  logic [SYNC-1:0] f_sy, n_sy;
  logic [6:0]      bank_f, bank_n;
  logic [AW-1:0]   lnk_f, lnk_n;

  wire f_pend = ~f_sy[SYNC-1];
  wire n_pend = ~n_sy[SYNC-1];
  wire in_f   = (mode == M_FST);
  wire in_n   = (mode == M_NRM);
  wire do_ret = eret & (in_f | in_n);
  wire take_f = take_ok & f_pend & ~fmask;
  wire take_n = take_ok & n_pend & ~nmask & ~take_f;
  wire [6:0]    cur_st = {nmask, fmask, mode};
  wire [6:0]    rst_st = in_f ? bank_f : bank_n;
  wire [AW-1:0] rst_lk = in_f ? lnk_f : lnk_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_sy <= '1;
      n_sy <= '1;
    end else begin
      f_sy <= {f_sy[SYNC-2:0], fst_req_n};
      n_sy <= {n_sy[SYNC-2:0], nrm_req_n};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode       <= M_USR;
      nmask      <= 1'b1;
      fmask      <= 1'b1;
      take       <= 1'b0;
      saved_we   <= 1'b0;
      ret_valid  <= 1'b0;
      vec_addr   <= '0;
      link       <= '0;
      saved_stat <= '0;
      ret_pc     <= '0;
      bank_f     <= '0;
      bank_n     <= '0;
      lnk_f      <= '0;
      lnk_n      <= '0;
    end else begin
      take      <= 1'b0;
      saved_we  <= 1'b0;
      ret_valid <= 1'b0;
      if (do_ret) begin
        nmask     <= rst_st[6];
        fmask     <= rst_st[5];
        mode      <= rst_st[4:0];
        ret_pc    <= rst_lk - AW'(4);
        ret_valid <= 1'b1;
      end else if (take_f) begin
        bank_f     <= cur_st;
        lnk_f      <= pc_in + AW'(4);
        link       <= pc_in + AW'(4);
        saved_stat <= {nmask, fmask, 1'b0, mode};
        saved_we   <= 1'b1;
        take       <= 1'b1;
        vec_addr   <= F_VEC;
        mode       <= M_FST;
        nmask      <= 1'b1;
        fmask      <= 1'b1;
      end else if (take_n) begin
        bank_n     <= cur_st;
        lnk_n      <= pc_in + AW'(4);
        link       <= pc_in + AW'(4);
        saved_stat <= {nmask, fmask, 1'b0, mode};
        saved_we   <= 1'b1;
        take       <= 1'b1;
        vec_addr   <= N_VEC;
        mode       <= M_NRM;
        nmask      <= 1'b1;
      end else if (mask_we) begin
        fmask <= mask_wdata[1];
        nmask <= mask_wdata[0];
      end
    end
  end
endmodule

module excp_entry_ctl_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          eret,
  input logic [AW-1:0] pc_in,
  input logic          take,
  input logic [4:0]    mode,
  input logic          nmask,
  input logic          fmask,
  input logic [AW-1:0] link,
  input logic          saved_we,
  input logic [7:0]    saved_stat,
  input logic          ret_valid
);
  assert_fast_masks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && mode == 5'b10001) |-> (nmask && fmask));

  assert_norm_keeps_f_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && mode == 5'b10010) |-> (nmask && fmask == saved_stat[6]));

  assert_link_R7: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (link == $past(pc_in) + AW'(4)));

  assert_saved_R7: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (saved_we && saved_stat == $past({nmask, fmask, 1'b0, mode})));

  assert_ret_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |-> $past(eret));

  assert_ret_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({take, ret_valid}));

  assert_user_eret_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (eret && mode == 5'b10000) |=> !ret_valid);
endmodule

bind excp_entry_ctl excp_entry_ctl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .eret(eret), .pc_in(pc_in), .take(take),
  .mode(mode), .nmask(nmask), .fmask(fmask), .link(link),
  .saved_we(saved_we), .saved_stat(saved_stat), .ret_valid(ret_valid)
);

// File: tb/excp_entry_ctl_tb.sv
module excp_entry_ctl_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        nrm_req_n = 1, fst_req_n = 1, take_ok = 1;
  logic [31:0] pc_in = 0;
  logic        mask_we = 0, eret = 0;
  logic [1:0]  mask_wdata = 0;
  logic        take, nmask, fmask, saved_we, ret_valid;
  logic [31:0] vec_addr, link, ret_pc;
  logic [4:0]  mode;
  logic [7:0]  saved_stat;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  excp_entry_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .nrm_req_n(nrm_req_n), .fst_req_n(fst_req_n),
    .take_ok(take_ok), .pc_in(pc_in), .mask_we(mask_we), .mask_wdata(mask_wdata),
    .eret(eret), .take(take), .vec_addr(vec_addr), .mode(mode), .nmask(nmask),
    .fmask(fmask), .link(link), .saved_we(saved_we), .saved_stat(saved_stat),
    .ret_valid(ret_valid), .ret_pc(ret_pc)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_take(output int cyc);
    cyc = 0;
    for (int i = 1; i <= 10; i++) begin
      @(negedge clk);
      if (take) begin cyc = i; break; end
    end
  endtask

  task automatic do_eret();
    eret = 1; step(1); eret = 0;
  endtask

  task automatic t_reset();
    chk("R1 mode", 32'(mode), 32'h10);
    chk("R1 masks", {30'b0, nmask, fmask}, 32'h3);
    chk("R1 strobes", {29'b0, take, saved_we, ret_valid}, 32'h0);
  endtask

  task automatic t_mask_write();
    mask_we = 1; mask_wdata = 2'b10; step(1); mask_we = 0;
    chk("R10 write 10", {30'b0, fmask, nmask}, 32'h2);
    mask_we = 1; mask_wdata = 2'b00; step(1); mask_we = 0;
    chk("R10 write 00", {30'b0, fmask, nmask}, 32'h0);
  endtask

  task automatic t_masked();
    int c;
    mask_we = 1; mask_wdata = 2'b11; step(1); mask_we = 0;
    nrm_req_n = 0; fst_req_n = 0;
    wait_take(c);
    chk("R6 masked no take", 32'(c), 0);
    nrm_req_n = 1; fst_req_n = 1; step(4);
    mask_we = 1; mask_wdata = 2'b00; step(1); mask_we = 0;
    take_ok = 0; nrm_req_n = 0;
    wait_take(c);
    chk("R6 take_ok low no take", 32'(c), 0);
    pc_in = 32'h500; take_ok = 1;
    wait_take(c);
    chk("R6 take at boundary", 32'(c), 1);
    chk("R2 normal vector", vec_addr, 32'h18);
    nrm_req_n = 1; step(3);
    do_eret();
    chk("R8 ret normal", ret_pc, 32'h500);
  endtask

  task automatic t_fast_entry();
    int c;
    pc_in = 32'h1000; fst_req_n = 0;
    wait_take(c);
    chk("R2 latency", 32'(c), 3);
    chk("R2 fast vector", vec_addr, 32'h1C);
    chk("R4 fast mode", 32'(mode), 32'h11);
    chk("R4 fast masks", {30'b0, nmask, fmask}, 32'h3);
    chk("R7 link", link, 32'h1004);
    chk("R7 saved strobe", 32'(saved_we), 1);
    chk("R7 saved status", 32'(saved_stat), 32'h10);
    fst_req_n = 1; step(3);
    do_eret();
    chk("R8 ret_valid", 32'(ret_valid), 1);
    chk("R8 ret_pc", ret_pc, 32'h1000);
    chk("R8 restored mode", 32'(mode), 32'h10);
    chk("R8 restored masks", {30'b0, nmask, fmask}, 32'h0);
    step(1);
    chk("R8 ret pulse ends", 32'(ret_valid), 0);
  endtask

  task automatic t_simul_and_preempt();
    int c;
    pc_in = 32'h3000; fst_req_n = 0; nrm_req_n = 0;
    wait_take(c);
    chk("R3 fast first latency", 32'(c), 3);
    chk("R3 fast first vector", vec_addr, 32'h1C);
    wait_take(c);
    chk("R3 normal held off", 32'(c), 0);
    fst_req_n = 1; step(3);
    do_eret();
    chk("R8 ret to user", 32'(mode), 32'h10);
    step(1);
    chk("R5 normal taken", 32'(take), 1);
    chk("R5 normal vector", vec_addr, 32'h18);
    chk("R5 normal mode", 32'(mode), 32'h12);
    chk("R5 masks n=1 f=0", {30'b0, nmask, fmask}, 32'h2);
    chk("R7 normal link", link, 32'h3004);
    pc_in = 32'h2000; fst_req_n = 0;
    wait_take(c);
    chk("R5 preempt latency", 32'(c), 3);
    chk("R5 preempt mode", 32'(mode), 32'h11);
    chk("R7 preempt saved", 32'(saved_stat), 32'h92);
    fst_req_n = 1; nrm_req_n = 1; step(3);
    do_eret();
    chk("R8 back to normal pc", ret_pc, 32'h2000);
    chk("R8 back to normal mode", 32'(mode), 32'h12);
    chk("R8 back to normal masks", {30'b0, nmask, fmask}, 32'h2);
    do_eret();
    chk("R8 back to user pc", ret_pc, 32'h3000);
    chk("R8 back to user", {25'b0, nmask, fmask, mode}, 32'h10);
  endtask

  task automatic t_user_eret();
    do_eret();
    chk("R9 user eret ignored", 32'(ret_valid), 0);
    chk("R9 user eret state", {25'b0, nmask, fmask, mode}, 32'h10);
  endtask

  task automatic t_eret_priority();
    int c;
    pc_in = 32'h4000; nrm_req_n = 0;
    wait_take(c);
    nrm_req_n = 1;
    take_ok = 0; fst_req_n = 0; step(4);
    take_ok = 1; eret = 1; mask_we = 1; mask_wdata = 2'b11;
    step(1);
    eret = 0; mask_we = 0;
    chk("R9 eret wins", 32'(ret_valid), 1);
    chk("R9 no take same edge", 32'(take), 0);
    chk("R9 mask write dropped", {25'b0, nmask, fmask, mode}, 32'h10);
    step(1);
    chk("R9 fast taken after", vec_addr, 32'h1C);
    chk("R9 fast take strobe", 32'(take), 1);
    fst_req_n = 1; step(3);
    do_eret();
  endtask

  initial begin
    step(2);
    rst_n = 1;
    step(1);
    t_reset();
    t_mask_write();
    t_masked();
    t_fast_entry();
    t_simul_and_preempt();
    t_user_eret();
    t_eret_priority();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule